// File: doc/BRIEF.md
# SDRAM Refresh Request Controller

This block times periodic auto-refresh for four SDRAM chip-select regions (chip selects 1, 3, 4 and 6) and requests the external bus whenever a region is due. Each region has its own 16-bit control word. The word holds an enable bit, a 2-bit divider select and a 6-bit interval factor. A free-running prescaler divides the system clock by 32, 64, 128 or 256. The region's interval counter counts pulses of the selected rate. When the factor is used up, a refresh becomes pending.

Pending refreshes go to the bus arbiter as a valid/ready stream. The payload is the chip-select number to refresh. `ref_valid` stays high until `ref_ready` accepts it. While it waits, the payload stays fixed. When several regions are due at once, the lowest chip-select number wins. When another bus master owns the external bus (`ext_busy`), the block does not offer the request. It pulls the active-low `refrq_n` toward that master and keeps it low until that master returns the bus with `ext_grant`. While the refresh sequencer reports a refresh cycle in progress, the address outputs keep the value they had just before the cycle began.

Top module: `refq_ctrl`

## Requirements
- R1: After reset every control word reads 0, `ref_valid` is low and `refrq_n` is high.
- R2: A write stores the enable in bit 15, the divider select in bits 9:8 and the interval factor in bits 5:0. A read of the same channel (address 0..3 = chip select 1, 3, 4, 6) returns these fields with every other bit 0.
- R3: With `ref_ready` held high and the bus free, two successive requests from one channel are exactly factor × (32 << select) clock cycles apart.
- R4: A channel whose enable bit is 0, or whose factor is 0, never raises a request.
- R5: While `ref_valid` is high and `ref_ready` low, the request and its `ref_cs` stay unchanged. Further expiries while pending are not queued, so one acceptance clears the channel until its next full interval.
- R6: When several channels are pending, the lowest chip-select number is offered first. `ref_cs` carries the chip-select number 1, 3, 4 or 6.
- R7: While `ext_busy` is high and a refresh is pending, `ref_valid` is low and `refrq_n` goes low one cycle later.
- R8: `refrq_n` returns high in the cycle after `ext_grant` is seen.
- R9: While `ref_active` is high, `addr_out` holds the value `addr_in` had in the cycle before `ref_active` rose. Otherwise `addr_out` follows `addr_in`.
- R10: A write to a channel reloads its interval counter and drops any refresh that channel has pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for a control word |
| reg_addr | input | 2 | Channel index for read and write |
| reg_wdata | input | 16 | Control word to write |
| reg_rdata | output | 16 | Control word of the addressed channel |
| ref_valid | output | 1 | Refresh request offered to the arbiter |
| ref_ready | input | 1 | Arbiter accepts the request |
| ref_cs | output | 3 | Chip-select number to refresh |
| ext_busy | input | 1 | Another bus master owns the external bus |
| ext_grant | input | 1 | That master hands the bus back |
| refrq_n | output | 1 | Active-low refresh request to the foreign master |
| ref_active | input | 1 | Refresh cycle in progress on the bus |
| addr_in | input | 24 | Address from the normal access path |
| addr_out | output | 24 | Address driven to the external bus |

## Verification
The hardest case to reach is two channels expiring on the same prescaler pulse while the arbiter stalls. Only that case shows both the priority order and the fixed payload under back-pressure. The stimulus reaches it by writing the same divider and factor into two channels on back-to-back cycles with `ref_ready` low. Both counters then reload before the shared pulse and both expire on it. The bench then accepts one request at a time.

// File: rtl/refq_pkg.sv
package refq_pkg;
  localparam int REG_W   = 16;
  localparam int EN_BIT  = 15;
  localparam int SEL_LSB = 8;
  localparam int SEL_W   = 2;
  localparam int FAC_W   = 6;
  localparam int CS_W    = 3;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [FAC_W-1:0] fac;
  } refq_cfg_t;

  function automatic refq_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    refq_cfg_t c;
    c.en  = w[EN_BIT];
    c.sel = w[SEL_LSB +: SEL_W];
    c.fac = w[FAC_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] word_from_cfg(input refq_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[FAC_W-1:0] = c.fac;
    return w;
  endfunction
endpackage

// File: rtl/refq_prescaler.sv
module refq_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int NSEL      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick
);
  localparam int CW = BASE_LOG2 + NSEL - 1;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // Rate k pulses once every 2**(BASE_LOG2+k) cycles, when its low bits are all ones.
  for (genvar k = 0; k < NSEL; k++) begin : g_tick
    assign tick[k] = &div_q[BASE_LOG2+k-1:0];
  end
endmodule

// File: rtl/refq_channel.sv
module refq_channel
  import refq_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  refq_cfg_t        wr_cfg,
  input  logic [NSEL-1:0]  tick,
  input  logic             ack,
  output logic             pending,
  output refq_cfg_t        cfg
);
  refq_cfg_t        cfg_q;
  logic [FAC_W-1:0] cnt_q;
  logic             pend_q;
  logic             running;
  logic             my_tick;

  assign running = cfg_q.en && (cfg_q.fac != '0);
  assign my_tick = tick[cfg_q.sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (wr) begin
      cfg_q  <= wr_cfg;
      cnt_q  <= wr_cfg.fac;
      pend_q <= 1'b0;
    end else if (ack) begin
      cnt_q  <= cfg_q.fac;
      pend_q <= 1'b0;
    end else if (running && my_tick && !pend_q) begin
      if (cnt_q <= 1) pend_q <= 1'b1;
      else            cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign pending = pend_q;
  assign cfg     = cfg_q;
endmodule

// File: rtl/refq_arbiter.sv
module refq_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  logic           ref_ready,
  input  logic           ext_busy,
  input  logic           ext_grant,
  output logic           ref_valid,
  output logic [IW-1:0]  sel_idx,
  output logic [NCH-1:0] ack_vec,
  output logic           refrq_n
);
  logic [IW-1:0] pick;
  logic [IW-1:0] lock_idx_q;
  logic          lock_q;
  logic          any_pend;
  logic          refrq_n_q;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = IW'(i);
    end
  end

  assign any_pend  = |pend;
  assign sel_idx   = (lock_q && pend[lock_idx_q]) ? lock_idx_q : pick;
  assign ref_valid = any_pend && !ext_busy;

  always_comb begin
    ack_vec = '0;
    if (ref_valid && ref_ready) ack_vec[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      refrq_n_q  <= 1'b1;
    end else begin
      lock_q     <= ref_valid && !ref_ready;
      lock_idx_q <= sel_idx;
      if (ext_grant)                refrq_n_q <= 1'b1;
      else if (any_pend && ext_busy) refrq_n_q <= 1'b0;
      else                          refrq_n_q <= 1'b1;
    end
  end

  assign refrq_n = refrq_n_q;
endmodule

// File: rtl/refq_addr_hold.sv
module refq_addr_hold #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [AW-1:0] a_in,
  output logic [AW-1:0] a_out
);
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (!active) last_q <= a_in;
  end

  assign a_out = active ? last_q : a_in;
endmodule

// File: rtl/refq_ctrl.sv
module refq_ctrl
  import refq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 24,
  parameter int BASE_LOG2 = 5,
  parameter logic [NCH*CS_W-1:0] CS_MAP = {3'd6, 3'd4, 3'd3, 3'd1},
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NSEL = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [IW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             ref_valid,
  input  logic             ref_ready,
  output logic [CS_W-1:0]  ref_cs,
  input  logic             ext_busy,
  input  logic             ext_grant,
  output logic             refrq_n,
  input  logic             ref_active,
  input  logic [AW-1:0]    addr_in,
  output logic [AW-1:0]    addr_out
);
  logic [NSEL-1:0] tick;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  ack_vec;
  logic [IW-1:0]   sel_idx;
  refq_cfg_t       cfg_arr [NCH];
  refq_cfg_t       wr_cfg;

  assign wr_cfg = cfg_from_word(reg_wdata);

  refq_prescaler #(.BASE_LOG2(BASE_LOG2), .NSEL(NSEL)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    refq_channel #(.NSEL(NSEL)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr_en && (reg_addr == IW'(c))),
      .wr_cfg(wr_cfg), .tick(tick), .ack(ack_vec[c]),
      .pending(pend[c]), .cfg(cfg_arr[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == IW'(c)) reg_rdata = word_from_cfg(cfg_arr[c]);
    end
  end

  refq_arbiter #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ref_ready(ref_ready),
    .ext_busy(ext_busy), .ext_grant(ext_grant), .ref_valid(ref_valid),
    .sel_idx(sel_idx), .ack_vec(ack_vec), .refrq_n(refrq_n)
  );

  assign ref_cs = CS_MAP[sel_idx*CS_W +: CS_W];

  refq_addr_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .active(ref_active),
    .a_in(addr_in), .a_out(addr_out)
  );
endmodule

// File: rtl/refq_ctrl_chk.sv
module refq_ctrl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr_en,
  input logic           ref_valid,
  input logic           ref_ready,
  input logic [2:0]     ref_cs,
  input logic           ext_busy,
  input logic           ext_grant,
  input logic           refrq_n,
  input logic           ref_active,
  input logic [AW-1:0]  addr_out,
  input logic [NCH-1:0] ack_vec
);
  assert_hold_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready && !reg_wr_en) |=> (ext_busy || (ref_valid && $stable(ref_cs))));

  assert_cs_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> (ref_cs == 3'd1 || ref_cs == 3'd3 || ref_cs == 3'd4 || ref_cs == 3'd6));

  assert_single_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));

  assert_fall_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refrq_n) |-> $past(ext_busy));

  assert_release_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_grant |=> refrq_n);

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_active && $past(ref_active)) |-> $stable(addr_out));
endmodule

bind refq_ctrl refq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .ref_valid(ref_valid),
  .ref_ready(ref_ready), .ref_cs(ref_cs), .ext_busy(ext_busy),
  .ext_grant(ext_grant), .refrq_n(refrq_n), .ref_active(ref_active),
  .addr_out(addr_out), .ack_vec(ack_vec)
);

// File: tb/tb_refq_ctrl.sv
`timescale 1ns/1ps
module tb_refq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ref_valid;
  logic        ref_ready = 1'b0;
  logic [2:0]  ref_cs;
  logic        ext_busy = 1'b0;
  logic        ext_grant = 1'b0;
  logic        refrq_n;
  logic        ref_active = 1'b0;
  logic [23:0] addr_in = '0;
  logic [23:0] addr_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refq_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input bit en, input int sel, input int fac);
    return {en, 5'd0, 2'(sel), 2'd0, 6'(fac)};
  endfunction

  task automatic wr(input int ch, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'(ch); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_valid(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ref_valid) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset_r1();
    chk(ref_valid == 1'b0, "R1 valid", int'(ref_valid), 0);
    chk(refrq_n == 1'b1, "R1 refrq_n", int'(refrq_n), 1);
    for (int c = 0; c < 4; c++) begin
      reg_addr = 2'(c); #1;
      chk(reg_rdata == 16'h0, "R1 reg", int'(reg_rdata), 0);
    end
  endtask

  task automatic t_readback_r2();
    wr(2, 16'hFFFF);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 16'h833F, "R2 readback", int'(reg_rdata), 16'h833F);
    wr(2, 16'h0120);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 16'h0120, "R2 readback2", int'(reg_rdata), 16'h0120);
    wr(2, 16'h0);
  endtask

  task automatic t_interval_r3(input int ch, input int sel, input int fac, input int cs);
    int a, b;
    ref_ready = 1'b1;
    wr(ch, word(1, sel, fac));
    wait_valid(20000, a);
    chk(a >= 0, "R3 first request", a, 0);
    chk(ref_cs == 3'(cs), "R6 cs number", int'(ref_cs), cs);
    wait_valid(20000, b);
    chk(b - a == fac * (32 << sel), "R3 interval", b - a, fac * (32 << sel));
    wr(ch, 16'h0);
    ref_ready = 1'b0;
  endtask

  task automatic t_disabled_r4();
    int a;
    wr(0, word(1, 0, 0));
    wr(1, word(0, 0, 5));
    wait_valid(400, a);
    chk(a < 0, "R4 no request", a, -1);
    wr(0, 16'h0); wr(1, 16'h0);
  endtask

  task automatic t_backpressure_r5();
    int a;
    bit stable_ok;
    ref_ready = 1'b0;
    wr(0, word(1, 0, 2));
    wait_valid(200, a);
    chk(a >= 0, "R5 request", a, 0);
    stable_ok = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!ref_valid || ref_cs != 3'd1) stable_ok = 1'b0;
    end
    chk(stable_ok, "R5 held under stall", int'(stable_ok), 1);
    ref_ready = 1'b1;
    @(negedge clk);
    ref_ready = 1'b0;
    stable_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      #1;
      if (ref_valid) stable_ok = 1'b0;
      @(negedge clk);
    end
    chk(stable_ok, "R5 no queued second request", int'(stable_ok), 1);
    wr(0, 16'h0);
  endtask

  task automatic t_priority_r6();
    int a;
    ref_ready = 1'b0;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = word(1, 0, 3);
    @(negedge clk);
    reg_addr = 2'd1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    wait_valid(300, a);
    @(negedge clk);
    chk(ref_cs == 3'd3, "R6 lowest cs first", int'(ref_cs), 3);
    ref_ready = 1'b1;
    @(negedge clk);
    ref_ready = 1'b0;
    chk(ref_valid && ref_cs == 3'd4, "R6 second cs", int'(ref_cs), 4);
    wr(1, 16'h0); wr(2, 16'h0);
  endtask

  task automatic t_foreign_r7_r8();
    int seen;
    seen = 0;
    ext_busy = 1'b1;
    wr(3, word(1, 0, 1));
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!refrq_n) begin seen = 1; break; end
    end
    chk(seen == 1, "R7 refrq_n low", int'(refrq_n), 0);
    chk(ref_valid == 1'b0, "R7 no valid while busy", int'(ref_valid), 0);
    @(negedge clk);
    chk(refrq_n == 1'b0, "R7 refrq_n stays low", int'(refrq_n), 0);
    ext_grant = 1'b1; ext_busy = 1'b0;
    @(negedge clk);
    ext_grant = 1'b0;
    chk(refrq_n == 1'b1, "R8 refrq_n released", int'(refrq_n), 1);
    chk(ref_valid && ref_cs == 3'd6, "R8 request after grant", int'(ref_cs), 6);
    wr(3, 16'h0);
  endtask

  task automatic t_addr_r9();
    @(negedge clk);
    addr_in = 24'h12_3456;
    @(negedge clk);
    ref_active = 1'b1; addr_in = 24'h65_4321; #1;
    chk(addr_out == 24'h12_3456, "R9 hold first", int'(addr_out), 24'h123456);
    @(negedge clk);
    addr_in = 24'h0A_BCDE; #1;
    chk(addr_out == 24'h12_3456, "R9 hold later", int'(addr_out), 24'h123456);
    @(negedge clk);
    ref_active = 1'b0; #1;
    chk(addr_out == 24'h0A_BCDE, "R9 follow", int'(addr_out), 24'hABCDE);
  endtask

  task automatic t_reload_r10();
    int a;
    ref_ready = 1'b0;
    wr(0, word(1, 0, 1));
    wait_valid(100, a);
    chk(a >= 0, "R10 request", a, 0);
    wr(0, word(1, 3, 63));
    chk(ref_valid == 1'b0, "R10 write drops pending", int'(ref_valid), 0);
    wr(0, 16'h0);
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_readback_r2();
    t_interval_r3(0, 0, 3, 1);
    t_interval_r3(1, 1, 2, 3);
    t_interval_r3(3, 3, 1, 6);
    t_disabled_r4();
    t_backpressure_r5();
    t_priority_r6();
    t_foreign_r7_r8();
    t_addr_r9();
    t_reload_r10();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule